// File: doc/BRIEF.md
# Fully Associative Translation Cache with Status Writeback

This block holds recently used translations from a 20-bit virtual page number to a page frame number, together with the referenced and modified bits of each translation. Every valid entry is compared against the requested page number at once, and a hit returns the frame number combinationally in the cycle of the request. A miss is flagged, and an external page table walker responds by presenting the entry on the fill port. The fill goes into a free slot if there is one; otherwise it displaces the least recently used entry, or a pseudo-random one when the replacement parameter selects that mode.

Software keeps the cache coherent with the page tables through two commands. One drops the entry for a single page, after its protection or other fields change in memory. The other clears every entry, for an address-space switch. It walks the array one slot per cycle and raises `busy` while it does so. When an entry leaves the array for any reason, and its status bits differ from the values it was loaded with, the block reports the page number and the current referenced and modified bits one cycle later. The page table can then be updated from that report.

Top module: `tlb_fa`

## Requirements
- R1: With `lk_valid` high and `busy` low, `lk_hit` rises in the same cycle when a valid entry holds `lk_vpn`, and `lk_pfn` then carries that entry's frame number. Otherwise `lk_miss` rises. The two are never high together.
- R2: A fill of a page that is not present goes into the lowest-numbered invalid slot. If every slot is valid, it goes into the slot used least recently, where a lookup hit and a fill each count as a use. After reset, slot N-1 is the least recent and slot 0 the most recent.
- R3: A lookup hit sets the entry's referenced bit. A hit with `lk_write` high also sets its modified bit. A bit that goes from 0 to 1 this way marks the entry as changed.
- R4: When a changed entry is displaced by a fill, `wb_valid` is high for exactly one cycle, in the cycle after the fill. In that cycle `wb_vpn`, `wb_ref` and `wb_mod` give the page and the entry's current bits. An entry whose bits still equal its fill values produces no report.
- R5: `inv_valid` removes the entry holding `inv_vpn`. If that entry was changed, it is reported as in R4. A page that is not present leaves every entry and every output unchanged.
- R6: `flush_all` while idle raises `busy` for the next N cycles. In the k-th of those cycles, slot k-1 is invalidated and reported if it was changed. While `busy` is high, lookups return neither hit nor miss, and fills, invalidates and flushes are ignored.
- R7: A fill of a page that is already present overwrites that same slot, so no page is ever held twice. A lookup of the same page in the same cycle sees the old frame number, and the fill's values are what remain.
- R8: After reset every slot is invalid, `busy` is low and `wb_valid` is low.
- R9: Within one idle cycle, `flush_all` takes priority over `inv_valid`, which takes priority over `fill_valid`. A lookup's status and recency update is dropped when the same cycle removes or overwrites the entry it hit, and it is also dropped in a flush cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is for a write access |
| lk_vpn | input | 20 | Page number to translate |
| lk_hit | output | 1 | Lookup found a valid entry |
| lk_miss | output | 1 | Lookup found no entry |
| lk_pfn | output | 20 | Frame number of the hit entry |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | 20 | Page number to install |
| fill_pfn | input | 20 | Frame number to install |
| fill_ref | input | 1 | Referenced bit as read from the page table |
| fill_mod | input | 1 | Modified bit as read from the page table |
| inv_valid | input | 1 | Invalidate one page |
| inv_vpn | input | 20 | Page to invalidate |
| flush_all | input | 1 | Invalidate every entry |
| busy | output | 1 | Flush walk in progress |
| wb_valid | output | 1 | Status writeback report |
| wb_vpn | output | 20 | Page being reported |
| wb_ref | output | 1 | Referenced bit to write back |
| wb_mod | output | 1 | Modified bit to write back |

## Verification
The hardest case to reach from the ports is a same-cycle collision. In it, a lookup and a fill or invalidate land on one entry, and that entry is at the same moment the least recent slot, so the recency order and the writeback both depend on which update wins. Directed cycles set up the collisions for fills to a present page, invalidate against fill, and flush against fill. A long seeded random phase then works a page pool larger than the array, so every slot is full and collisions with the victim slot happen often. Each cycle is compared against a behavioural model that keeps recency as an ordered queue.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [0:0] {
        REPL_LRU  = 1'b0,
        REPL_RAND = 1'b1
    } repl_e;

    // 16-bit maximal-length Fibonacci shift register step
    function automatic logic [15:0] lfsr16_next(logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int N     = 16,
    parameter int VPN_W = 20,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]            vld,
    input  logic [N-1:0][VPN_W-1:0] tags,
    input  logic [VPN_W-1:0]        key,
    output logic                    hit,
    output logic [IDX_W-1:0]        idx
);

    logic [N-1:0] eq;

    // one comparator per slot, all in parallel
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign eq[g] = vld[g] && (tags[g] == key);
    end

    always_comb begin
        hit = |eq;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (eq[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
#(
    parameter int    N     = 16,
    parameter int    IDX_W = $clog2(N),
    parameter repl_e MODE  = REPL_LRU
) (
    input  logic [N-1:0]            vld,
    input  logic [N-1:0][IDX_W-1:0] age,
    input  logic [IDX_W-1:0]        rnd,
    output logic [IDX_W-1:0]        idx
);

    logic             free_found;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] lru_idx;

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        // descending scan leaves the lowest free slot
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
        lru_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (age[i] == IDX_W'(N - 1)) lru_idx = IDX_W'(i);
        end
        if (free_found)           idx = free_idx;
        else if (MODE == REPL_LRU) idx = lru_idx;
        else                       idx = rnd;
    end

endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
    import tlb_pkg::*;
#(
    parameter int    N     = 16,
    parameter int    VPN_W = 20,
    parameter int    PFN_W = 20,
    parameter repl_e MODE  = REPL_LRU
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic             lk_write,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic [PFN_W-1:0] lk_pfn,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             fill_ref,
    input  logic             fill_mod,
    input  logic             inv_valid,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic             flush_all,
    output logic             busy,
    output logic             wb_valid,
    output logic [VPN_W-1:0] wb_vpn,
    output logic             wb_ref,
    output logic             wb_mod
);

    localparam int               IDX_W = $clog2(N);
    localparam logic [IDX_W-1:0] LAST  = IDX_W'(N - 1);

    typedef logic [N-1:0][IDX_W-1:0] age_t;

    typedef struct packed {
        logic [N-1:0]            vld;
        logic [N-1:0][VPN_W-1:0] tag;
        logic [N-1:0][PFN_W-1:0] pfn;
        logic [N-1:0]            rf;
        logic [N-1:0]            md;
        logic [N-1:0]            chg;
        age_t                    age;
        logic                    busy;
        logic [IDX_W-1:0]        scan;
        logic [15:0]             lfsr;
        logic                    wb_v;
        logic [VPN_W-1:0]        wb_vpn;
        logic                    wb_ref;
        logic                    wb_mod;
    } st_t;

    function automatic st_t reset_state();
        st_t r = '0;
        for (int i = 0; i < N; i++) r.age[i] = IDX_W'(i);
        r.lfsr = 16'hACE1;
        return r;
    endfunction

    // mark slot t most recent; older-than-t slots stay put
    function automatic age_t touch(age_t a, logic [IDX_W-1:0] t);
        age_t r = a;
        for (int i = 0; i < N; i++) begin
            if (a[i] < a[t]) r[i] = a[i] + 1'b1;
        end
        r[t] = '0;
        return r;
    endfunction

    st_t s_q, s_d;

    logic             lk_m_hit;
    logic [IDX_W-1:0] lk_idx;
    logic             mk_hit;
    logic [IDX_W-1:0] mk_idx;
    logic [VPN_W-1:0] mk_key;
    logic [IDX_W-1:0] vic_idx;
    logic [IDX_W-1:0] tgt;
    logic             rm_v;
    logic [IDX_W-1:0] rm_idx;

    // views for the bound checker
    logic [N-1:0]            ent_vld;
    logic [N-1:0][VPN_W-1:0] ent_tag;
    assign ent_vld = s_q.vld;
    assign ent_tag = s_q.tag;

    assign mk_key = inv_valid ? inv_vpn : fill_vpn;

    tlb_match #(.N(N), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_lk_match (
        .vld (s_q.vld),
        .tags(s_q.tag),
        .key (lk_vpn),
        .hit (lk_m_hit),
        .idx (lk_idx)
    );

    tlb_match #(.N(N), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_mk_match (
        .vld (s_q.vld),
        .tags(s_q.tag),
        .key (mk_key),
        .hit (mk_hit),
        .idx (mk_idx)
    );

    tlb_victim #(.N(N), .IDX_W(IDX_W), .MODE(MODE)) u_victim (
        .vld(s_q.vld),
        .age(s_q.age),
        .rnd(s_q.lfsr[IDX_W-1:0]),
        .idx(vic_idx)
    );

    always_comb begin
        s_d      = s_q;
        s_d.wb_v = 1'b0;
        s_d.lfsr = lfsr16_next(s_q.lfsr);

        lk_hit  = lk_valid && !s_q.busy && lk_m_hit;
        lk_miss = lk_valid && !s_q.busy && !lk_m_hit;
        lk_pfn  = s_q.pfn[lk_idx];

        tgt    = mk_hit ? mk_idx : vic_idx;
        rm_v   = 1'b0;
        rm_idx = '0;

        if (s_q.busy) begin
            if (s_q.vld[s_q.scan] && s_q.chg[s_q.scan]) begin
                s_d.wb_v   = 1'b1;
                s_d.wb_vpn = s_q.tag[s_q.scan];
                s_d.wb_ref = s_q.rf[s_q.scan];
                s_d.wb_mod = s_q.md[s_q.scan];
            end
            s_d.vld[s_q.scan] = 1'b0;
            if (s_q.scan == LAST) s_d.busy = 1'b0;
            s_d.scan = s_q.scan + 1'b1;
        end else if (flush_all) begin
            s_d.busy = 1'b1;
            s_d.scan = '0;
        end else begin
            if (inv_valid) begin
                if (mk_hit) begin
                    rm_v   = 1'b1;
                    rm_idx = mk_idx;
                    if (s_q.chg[mk_idx]) begin
                        s_d.wb_v   = 1'b1;
                        s_d.wb_vpn = s_q.tag[mk_idx];
                        s_d.wb_ref = s_q.rf[mk_idx];
                        s_d.wb_mod = s_q.md[mk_idx];
                    end
                    s_d.vld[mk_idx] = 1'b0;
                end
            end else if (fill_valid) begin
                rm_v   = 1'b1;
                rm_idx = tgt;
                if (s_q.vld[tgt] && s_q.chg[tgt]) begin
                    s_d.wb_v   = 1'b1;
                    s_d.wb_vpn = s_q.tag[tgt];
                    s_d.wb_ref = s_q.rf[tgt];
                    s_d.wb_mod = s_q.md[tgt];
                end
                s_d.vld[tgt] = 1'b1;
                s_d.tag[tgt] = fill_vpn;
                s_d.pfn[tgt] = fill_pfn;
                s_d.rf[tgt]  = fill_ref;
                s_d.md[tgt]  = fill_mod;
                s_d.chg[tgt] = 1'b0;
            end

            if (lk_hit && !(rm_v && (rm_idx == lk_idx))) begin
                s_d.rf[lk_idx] = 1'b1;
                if (lk_write) s_d.md[lk_idx] = 1'b1;
                if (!s_q.rf[lk_idx] || (lk_write && !s_q.md[lk_idx]))
                    s_d.chg[lk_idx] = 1'b1;
                s_d.age = touch(s_d.age, lk_idx);
            end

            if (!inv_valid && fill_valid) s_d.age = touch(s_d.age, tgt);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= reset_state();
        else        s_q <= s_d;
    end

    assign busy     = s_q.busy;
    assign wb_valid = s_q.wb_v;
    assign wb_vpn   = s_q.wb_vpn;
    assign wb_ref   = s_q.wb_ref;
    assign wb_mod   = s_q.wb_mod;

endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
    parameter int N     = 16,
    parameter int VPN_W = 20
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    lk_hit,
    input logic                    lk_miss,
    input logic                    busy,
    input logic                    flush_all,
    input logic                    fill_valid,
    input logic                    inv_valid,
    input logic                    wb_valid,
    input logic [N-1:0]            ent_vld,
    input logic [N-1:0][VPN_W-1:0] ent_tag
);

    logic dup;

    always_comb begin
        dup = 1'b0;
        for (int i = 0; i < N; i++) begin
            for (int j = i + 1; j < N; j++) begin
                if (ent_vld[i] && ent_vld[j] && ent_tag[i] == ent_tag[j]) dup = 1'b1;
            end
        end
    end

    p_hit_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_miss));

    p_wb_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(busy || inv_valid || fill_valid));

    p_flush_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_all && !busy) |=> busy);

    p_busy_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!lk_hit && !lk_miss));

    p_no_dup_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dup);

endmodule

bind tlb_fa tlb_fa_chk #(.N(N), .VPN_W(VPN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_hit    (lk_hit),
    .lk_miss   (lk_miss),
    .busy      (busy),
    .flush_all (flush_all),
    .fill_valid(fill_valid),
    .inv_valid (inv_valid),
    .wb_valid  (wb_valid),
    .ent_vld   (ent_vld),
    .ent_tag   (ent_tag)
);

// File: tb/tlb_fa_tb.sv
`timescale 1ns/1ps
module tlb_fa_tb;

    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 0, lk_write = 0;
    logic [19:0] lk_vpn = '0;
    logic        lk_hit, lk_miss;
    logic [19:0] lk_pfn;
    logic        fill_valid = 0, fill_ref = 0, fill_mod = 0;
    logic [19:0] fill_vpn = '0, fill_pfn = '0;
    logic        inv_valid = 0;
    logic [19:0] inv_vpn = '0;
    logic        flush_all = 0;
    logic        busy, wb_valid, wb_ref, wb_mod;
    logic [19:0] wb_vpn;

    always #10 clk = ~clk;

    tlb_fa u_dut (.*);

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R8";

    // behavioural reference model
    bit          m_vld[N], m_rf[N], m_md[N], m_chg[N];
    logic [19:0] m_tag[N], m_pfn[N];
    int          m_lru[$];
    bit          m_busy;
    int          m_scan;
    bit          e_wbv, e_wbr, e_wbm;
    logic [19:0] e_wbvpn;
    bit          n_wbv, n_wbr, n_wbm;
    logic [19:0] n_wbvpn;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int mfind(logic [19:0] v);
        for (int i = 0; i < N; i++) if (m_vld[i] && m_tag[i] == v) return i;
        return -1;
    endfunction

    function automatic int mvictim();
        for (int i = 0; i < N; i++) if (!m_vld[i]) return i;
        return m_lru[$];
    endfunction

    task automatic mtouch(int t);
        for (int i = 0; i < m_lru.size(); i++) begin
            if (m_lru[i] == t) begin
                m_lru.delete(i);
                break;
            end
        end
        m_lru.push_front(t);
    endtask

    task automatic mwb(int s);
        n_wbv = 1; n_wbvpn = m_tag[s]; n_wbr = m_rf[s]; n_wbm = m_md[s];
    endtask

    task automatic model_reset();
        m_lru.delete();
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 0; m_rf[i] = 0; m_md[i] = 0; m_chg[i] = 0;
            m_lru.push_back(i);
        end
        m_busy = 0; m_scan = 0; e_wbv = 0;
    endtask

    task automatic cyc(bit lv, bit lw, logic [19:0] lvpn,
                       bit fv, logic [19:0] fvpn, logic [19:0] fpfn, bit fr, bit fm,
                       bit iv, logic [19:0] ivpn, bit fl);
        int  h, rm, t;
        bit  eh, em;
        lk_valid = lv; lk_write = lw; lk_vpn = lvpn;
        fill_valid = fv; fill_vpn = fvpn; fill_pfn = fpfn; fill_ref = fr; fill_mod = fm;
        inv_valid = iv; inv_vpn = ivpn; flush_all = fl;
        #5;
        h  = mfind(lvpn);
        eh = lv && !m_busy && h >= 0;
        em = lv && !m_busy && h < 0;
        chk(cur_req, "lk_hit", lk_hit, eh);
        chk(cur_req, "lk_miss", lk_miss, em);
        if (eh) chk(cur_req, "lk_pfn", lk_pfn, m_pfn[h]);
        chk("R6", "busy", busy, m_busy);
        chk("R4", "wb_valid", wb_valid, e_wbv);
        if (e_wbv) begin
            chk("R4", "wb_vpn", wb_vpn, e_wbvpn);
            chk("R4", "wb_ref", wb_ref, e_wbr);
            chk("R4", "wb_mod", wb_mod, e_wbm);
        end
        n_wbv = 0;
        if (m_busy) begin
            if (m_vld[m_scan] && m_chg[m_scan]) mwb(m_scan);
            m_vld[m_scan] = 0;
            if (m_scan == N - 1) begin m_busy = 0; m_scan = 0; end
            else m_scan++;
        end else if (fl) begin
            m_busy = 1; m_scan = 0;
        end else begin
            rm = -1; t = -1;
            if (iv) begin
                t = mfind(ivpn);
                if (t >= 0) begin
                    if (m_chg[t]) mwb(t);
                    m_vld[t] = 0;
                    rm = t;
                end
            end else if (fv) begin
                t = mfind(fvpn);
                if (t < 0) t = mvictim();
                if (m_vld[t] && m_chg[t]) mwb(t);
                m_vld[t] = 1; m_tag[t] = fvpn; m_pfn[t] = fpfn;
                m_rf[t] = fr; m_md[t] = fm; m_chg[t] = 0;
                rm = t;
            end
            if (eh && h != rm) begin
                if (!m_rf[h] || (lw && !m_md[h])) m_chg[h] = 1;
                m_rf[h] = 1;
                if (lw) m_md[h] = 1;
                mtouch(h);
            end
            if (!iv && fv) mtouch(t);
        end
        e_wbv = n_wbv; e_wbvpn = n_wbvpn; e_wbr = n_wbr; e_wbm = n_wbm;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();                   cyc(0,0,0, 0,0,0,0,0, 0,0, 0); endtask
    task automatic look(logic [19:0] v, bit w); cyc(1,w,v, 0,0,0,0,0, 0,0, 0); endtask
    task automatic fill(logic [19:0] v, logic [19:0] p, bit r, bit m);
        cyc(0,0,0, 1,v,p,r,m, 0,0, 0);
    endtask
    task automatic inval(logic [19:0] v);    cyc(0,0,0, 0,0,0,0,0, 1,v, 0); endtask
    task automatic flush();                  cyc(0,0,0, 0,0,0,0,0, 0,0, 1); endtask

    bit done = 0;
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        cur_req = "R8";
        idle();
        look(20'h100, 0);

        cur_req = "R2";
        for (int i = 0; i < N; i++) fill(20'h100 + i, 20'h8000 + i, 0, 0);
        cur_req = "R1";
        for (int i = 0; i < N; i++) look(20'h100 + i, 0);
        look(20'h7777, 0);

        cur_req = "R3";
        look(20'h103, 1);
        look(20'h105, 0);
        look(20'h103, 1);

        cur_req = "R2";
        fill(20'h200, 20'h0AAA, 0, 0);
        fill(20'h201, 20'h0AAB, 0, 0);
        look(20'h100, 0);
        look(20'h102, 0);

        cur_req = "R4";
        inval(20'h200);
        fill(20'h300, 20'h0CCC, 1, 1);
        look(20'h300, 1);
        inval(20'h300);
        idle();

        cur_req = "R5";
        inval(20'h105);
        inval(20'h999);
        look(20'h105, 0);
        idle();

        cur_req = "R7";
        cyc(1,0,20'h104, 1,20'h104,20'h1234,0,0, 0,0, 0);
        look(20'h104, 0);
        fill(20'h104, 20'h4321, 1, 0);
        look(20'h104, 1);

        cur_req = "R9";
        cyc(1,0,20'h106, 1,20'h106,20'h5555,0,0, 1,20'h106, 0);
        look(20'h106, 0);
        cyc(1,1,20'h107, 1,20'h107,20'h6666,0,0, 0,0, 0);
        look(20'h107, 0);

        cur_req = "R6";
        look(20'h108, 1);
        cyc(1,0,20'h109, 1,20'h444,20'h4444,0,0, 0,0, 1);
        for (int i = 0; i < N; i++) cyc(1,1,20'h10A, 1,20'h555,20'h5,0,0, 1,20'h10B, 1);
        look(20'h10A, 0);
        look(20'h444, 0);

        cur_req = "R9";
        seed = 32'h1234_5678;
        for (int k = 0; k < 3000; k++) begin
            bit lv, lw, fv, fr, fm, iv, fl;
            logic [19:0] lvp, fvp, ivp;
            seed = seed * 1103515245 + 12345; lv = seed[20]; lw = seed[21];
            lvp = 20'h400 + 20'(seed[27:23] % 24);
            seed = seed * 1103515245 + 12345; fv = seed[18] & seed[19];
            fr = seed[20]; fm = seed[21] & seed[20];
            fvp = 20'h400 + 20'(seed[28:24] % 24);
            seed = seed * 1103515245 + 12345; iv = (seed[23:20] == 0);
            ivp = 20'h400 + 20'(seed[30:26] % 24);
            fl = (seed[16:10] == 0);
            cyc(lv, lw, lvp, fv, fvp, 20'(seed[19:0] ^ 20'hF0F0F), fr, fm, iv, ivp, fl);
        end
        for (int i = 0; i < N + 2; i++) idle();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule